// File: doc/BRIEF.md
# Sleep and Interrupt Wake Controller

This block manages the low-power state of a small processor core. The core's instruction decoder raises a one-cycle sleep request when it executes a sleep opcode. The controller then checks whether an enabled interrupt is already pending. If one is, the request completes as a no-op: the core stays awake, the watchdog is not cleared and neither status bit changes. If none is, the controller makes the sleep real. It pulses the watchdog clear, sets the timeout bit, clears the power-down bit and holds the core clock enable low.

An interrupt is pending when any source has both its enable bit and its flag bit set. This holds whether or not global interrupts are enabled. A pending interrupt during sleep wakes the core. If global interrupts are enabled, one dummy cycle follows and then a one-cycle load of the handler vector address into the program counter. If they are disabled, a one-cycle resume strobe tells the core to continue with the next sequential instruction. Software reads the power-down bit after the sleep step: if it is still set, the sleep ran as a no-op.

An explicit watchdog-clear command sets both status bits and pulses the watchdog clear. A timeout event from the external watchdog counter clears the timeout bit.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: After reset, `asleep`=0, `coreClkEn`=1, `powerDownBit`=1, `timeoutBit`=1, and `wdtClr`, `vecLoad` and `resumeInline` are all 0.
- R2: The pending condition is registered. At each clock edge it takes the OR, over all sources, of `intEn[i] & intFlag[i]`. It does not depend on `globalIntEn`.
- R3: A sleep request taken while running, with the pending register already 1 at that edge, is a no-op. In the next cycle `asleep`=0 and `wdtClr`=0, and `timeoutBit` and `powerDownBit` keep their values.
- R4: A sleep request taken while running, with the pending register 0 at that edge, is a real sleep. In the next cycle `asleep`=1, `coreClkEn`=0, `timeoutBit`=1, `powerDownBit`=0 and `wdtClr`=1. In the cycle after that, `wdtClr`=0.
- R5: While asleep, the block stays asleep as long as the pending register is 0. It is awake one cycle after the edge at which the pending register is seen as 1. A condition that first appears at the same edge as the sleep request still gives a real sleep, and the wake follows one cycle later.
- R6: On a wake with `globalIntEn`=1, the first awake cycle is a dummy cycle with `vecLoad`=0 and `resumeInline`=0. The next cycle has `vecLoad`=1 for one cycle, with `vecAddr` equal to 16'h0008.
- R7: On a wake with `globalIntEn`=0, the first awake cycle has `resumeInline`=1 for one cycle and `vecLoad` stays 0.
- R8: `wdtClrCmd` gives a single `wdtClr` pulse in the next cycle and sets `timeoutBit` and `powerDownBit` to 1. If it coincides with a real sleep entry, there is still only one pulse and `powerDownBit` becomes 0.
- R9: `wdtTimeout` clears `timeoutBit` in the next cycle. If it coincides with `wdtClrCmd` or with a real sleep entry, the set wins and `timeoutBit` becomes 1.
- R10: A sleep request taken while asleep or in the dummy cycle has no effect. No `wdtClr` pulse follows and the wake sequence continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sleepReq | input | 1 | One-cycle request from the decoder when a sleep opcode executes |
| wdtClrCmd | input | 1 | One-cycle explicit watchdog-clear command |
| wdtTimeout | input | 1 | One-cycle event from the external watchdog counter |
| globalIntEn | input | 1 | Global interrupt enable |
| intEn | input | N_SRC | Per-source interrupt enables |
| intFlag | input | N_SRC | Per-source interrupt flags |
| asleep | output | 1 | High while the core is in sleep |
| coreClkEn | output | 1 | Core clock enable, low while asleep |
| wdtClr | output | 1 | One-cycle clear pulse to the watchdog and its postscaler |
| timeoutBit | output | 1 | Timeout status bit |
| powerDownBit | output | 1 | Power-down status bit |
| vecLoad | output | 1 | One-cycle strobe that loads `vecAddr` into the program counter |
| vecAddr | output | PC_W | Interrupt handler vector address |
| resumeInline | output | 1 | One-cycle strobe that resumes sequential execution after a wake |

## Verification
The riskiest collisions are a sleep request landing in the same cycle as either a watchdog-clear command or the first appearance of an enabled interrupt. Each changes which status update or pulse wins. The bench drives the clear command together with both no-op and real sleeps, and raises an interrupt flag in the very cycle of a sleep request. It then compares the status bits and the pulse count with the outcome the requirements give for each pairing. A full sweep over every enable and flag pattern, for both values of the global enable, decides from the bitwise AND whether each request should be a no-op or a sleep. It then times the wake and vector sequence cycle by cycle.

// File: rtl/swc_pkg.sv
package swc_pkg;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_SLEEP = 2'd1,
    ST_DUMMY = 2'd2
  } swcState_t;

  // strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic enterSleep;
    logic wakeInline;
    logic loadVec;
  } swcStrobe_t;

endpackage

// File: rtl/swc_control.sv
module swc_control
  import swc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sleepReq,
  input  logic       pending,
  input  logic       globalIntEn,
  output swcStrobe_t strb,
  output logic       asleep,
  output logic       inDummy,
  output logic       coreClkEn
);

  swcState_t state, stateNxt;
  logic      clkEnQ;

  always_comb begin
    stateNxt = state;
    strb     = '0;
    case (state)
      ST_RUN: begin
        if (sleepReq && !pending) begin
          stateNxt        = ST_SLEEP;
          strb.enterSleep = 1'b1;
        end
      end
      ST_SLEEP: begin
        if (pending) begin
          if (globalIntEn) begin
            stateNxt = ST_DUMMY;
          end else begin
            stateNxt        = ST_RUN;
            strb.wakeInline = 1'b1;
          end
        end
      end
      ST_DUMMY: begin
        stateNxt     = ST_RUN;
        strb.loadVec = 1'b1;
      end
      default: stateNxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_RUN;
      clkEnQ <= 1'b1;
    end else begin
      state  <= stateNxt;
      clkEnQ <= (stateNxt != ST_SLEEP);
    end
  end

  assign asleep    = (state == ST_SLEEP);
  assign inDummy   = (state == ST_DUMMY);
  assign coreClkEn = clkEnQ;

endmodule

// File: rtl/swc_datapath.sv
module swc_datapath
  import swc_pkg::*;
#(
  parameter int N_SRC       = 8,
  parameter int PC_W        = 16,
  parameter int VECTOR_ADDR = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [N_SRC-1:0] intEn,
  input  logic [N_SRC-1:0] intFlag,
  input  logic             wdtClrCmd,
  input  logic             wdtTimeout,
  input  swcStrobe_t       strb,
  output logic             pending,
  output logic             wdtClr,
  output logic             timeoutBit,
  output logic             powerDownBit,
  output logic             vecLoad,
  output logic [PC_W-1:0]  vecAddr,
  output logic             resumeInline
);

  localparam logic [PC_W-1:0] VEC = PC_W'(VECTOR_ADDR);

  logic [N_SRC-1:0] armed;
  logic             pendQ, clrQ, toQ, pdQ, vecQ, resQ;

  assign armed = intEn & intFlag;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ <= 1'b0;
      clrQ  <= 1'b0;
      toQ   <= 1'b1;
      pdQ   <= 1'b1;
      vecQ  <= 1'b0;
      resQ  <= 1'b0;
    end else begin
      pendQ <= |armed;
      clrQ  <= strb.enterSleep | wdtClrCmd;
      if (strb.enterSleep || wdtClrCmd) toQ <= 1'b1;
      else if (wdtTimeout)              toQ <= 1'b0;
      if (strb.enterSleep)              pdQ <= 1'b0;
      else if (wdtClrCmd)               pdQ <= 1'b1;
      vecQ  <= strb.loadVec;
      resQ  <= strb.wakeInline;
    end
  end

  assign pending      = pendQ;
  assign wdtClr       = clrQ;
  assign timeoutBit   = toQ;
  assign powerDownBit = pdQ;
  assign vecLoad      = vecQ;
  assign vecAddr      = VEC;
  assign resumeInline = resQ;

endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl
  import swc_pkg::*;
#(
  parameter int N_SRC       = 8,
  parameter int PC_W        = 16,
  parameter int VECTOR_ADDR = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sleepReq,
  input  logic             wdtClrCmd,
  input  logic             wdtTimeout,
  input  logic             globalIntEn,
  input  logic [N_SRC-1:0] intEn,
  input  logic [N_SRC-1:0] intFlag,
  output logic             asleep,
  output logic             coreClkEn,
  output logic             wdtClr,
  output logic             timeoutBit,
  output logic             powerDownBit,
  output logic             vecLoad,
  output logic [PC_W-1:0]  vecAddr,
  output logic             resumeInline
);

  swcStrobe_t strb;
  logic       pending;
  logic       inDummy;

  swc_control i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .sleepReq   (sleepReq),
    .pending    (pending),
    .globalIntEn(globalIntEn),
    .strb       (strb),
    .asleep     (asleep),
    .inDummy    (inDummy),
    .coreClkEn  (coreClkEn)
  );

  swc_datapath #(
    .N_SRC      (N_SRC),
    .PC_W       (PC_W),
    .VECTOR_ADDR(VECTOR_ADDR)
  ) i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .intEn       (intEn),
    .intFlag     (intFlag),
    .wdtClrCmd   (wdtClrCmd),
    .wdtTimeout  (wdtTimeout),
    .strb        (strb),
    .pending     (pending),
    .wdtClr      (wdtClr),
    .timeoutBit  (timeoutBit),
    .powerDownBit(powerDownBit),
    .vecLoad     (vecLoad),
    .vecAddr     (vecAddr),
    .resumeInline(resumeInline)
  );

endmodule

// File: rtl/sleep_wake_ctrl_chk.sv
module sleep_wake_ctrl_chk (
  input logic clk,
  input logic rstN,
  input logic sleepReq,
  input logic wdtClrCmd,
  input logic globalIntEn,
  input logic pending,
  input logic inDummy,
  input logic asleep,
  input logic coreClkEn,
  input logic wdtClr,
  input logic timeoutBit,
  input logic powerDownBit,
  input logic vecLoad,
  input logic resumeInline
);

  a_r1_clk_gate: assert property (@(posedge clk) disable iff (!rstN)
    coreClkEn == !asleep);

  a_r3_nop_sleep: assert property (@(posedge clk) disable iff (!rstN)
    (sleepReq && !asleep && !inDummy && pending && !wdtClrCmd)
    |=> (!asleep && !wdtClr && $stable(powerDownBit)));

  a_r4_real_sleep: assert property (@(posedge clk) disable iff (!rstN)
    (sleepReq && !asleep && !inDummy && !pending)
    |=> (asleep && wdtClr && timeoutBit && !powerDownBit));

  a_r5_stay_asleep: assert property (@(posedge clk) disable iff (!rstN)
    (asleep && !pending) |=> asleep);

  a_r5_wake: assert property (@(posedge clk) disable iff (!rstN)
    (asleep && pending) |=> !asleep);

  a_r6_vec_after_dummy: assert property (@(posedge clk) disable iff (!rstN)
    vecLoad |-> $past(inDummy));

  a_r7_inline_resume: assert property (@(posedge clk) disable iff (!rstN)
    resumeInline |-> ($past(asleep) && !$past(globalIntEn)));

  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({asleep, vecLoad, resumeInline}));

  a_r8_clr_source: assert property (@(posedge clk) disable iff (!rstN)
    wdtClr |-> $past(wdtClrCmd || sleepReq));

  a_r10_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (sleepReq && (asleep || inDummy) && !wdtClrCmd) |=> !wdtClr);

endmodule

bind sleep_wake_ctrl sleep_wake_ctrl_chk i_chk (
  .clk         (clk),
  .rstN        (rstN),
  .sleepReq    (sleepReq),
  .wdtClrCmd   (wdtClrCmd),
  .globalIntEn (globalIntEn),
  .pending     (pending),
  .inDummy     (inDummy),
  .asleep      (asleep),
  .coreClkEn   (coreClkEn),
  .wdtClr      (wdtClr),
  .timeoutBit  (timeoutBit),
  .powerDownBit(powerDownBit),
  .vecLoad     (vecLoad),
  .resumeInline(resumeInline)
);

// File: tb/test_sleep_wake_ctrl.sv
`timescale 1ns/1ps
module test_sleep_wake_ctrl;

  localparam int NS = 4;

  logic          clk = 1'b0;
  logic          rstN;
  logic          sleepReq, wdtClrCmd, wdtTimeout, globalIntEn;
  logic [NS-1:0] intEn, intFlag;
  logic          asleep, coreClkEn, wdtClr, timeoutBit, powerDownBit;
  logic          vecLoad, resumeInline;
  logic [15:0]   vecAddr;

  int nChecks = 0;
  int nErr    = 0;
  bit done    = 0;

  always #2.5 clk = ~clk;

  sleep_wake_ctrl #(.N_SRC(NS), .PC_W(16), .VECTOR_ADDR(8)) i_sleep_wake_ctrl (
    .clk(clk), .rstN(rstN), .sleepReq(sleepReq), .wdtClrCmd(wdtClrCmd),
    .wdtTimeout(wdtTimeout), .globalIntEn(globalIntEn), .intEn(intEn),
    .intFlag(intFlag), .asleep(asleep), .coreClkEn(coreClkEn), .wdtClr(wdtClr),
    .timeoutBit(timeoutBit), .powerDownBit(powerDownBit), .vecLoad(vecLoad),
    .vecAddr(vecAddr), .resumeInline(resumeInline)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // wake from sleep through a flagged source and check the sequence
  task automatic wakeAndCheck(input logic gie);
    globalIntEn = gie;
    intEn = '1; intFlag = 4'b0100;
    step();
    chk("R5 still asleep while pending registers", asleep, 1);
    step();
    chk("R5 awake", asleep, 0);
    chk("R5 clock enabled", coreClkEn, 1);
    if (gie) begin
      chk("R6 dummy no vec", vecLoad, 0);
      chk("R6 dummy no resume", resumeInline, 0);
      step();
      chk("R6 vec load", vecLoad, 1);
      chk("R6 vec addr", vecAddr, 16'h0008);
      step();
      chk("R6 vec pulse ends", vecLoad, 0);
    end else begin
      chk("R7 resume", resumeInline, 1);
      chk("R7 no vec", vecLoad, 0);
      step();
      chk("R7 resume ends", resumeInline, 0);
      chk("R7 still no vec", vecLoad, 0);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nErr++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    rstN = 0; sleepReq = 0; wdtClrCmd = 0; wdtTimeout = 0; globalIntEn = 0;
    intEn = '0; intFlag = '0;
    repeat (3) step();
    rstN = 1;
    step();
    chk("R1 asleep", asleep, 0);
    chk("R1 clk en", coreClkEn, 1);
    chk("R1 pd", powerDownBit, 1);
    chk("R1 to", timeoutBit, 1);
    chk("R1 wdtClr", wdtClr, 0);
    chk("R1 vecLoad", vecLoad, 0);
    chk("R1 resume", resumeInline, 0);

    // sweep: every enable/flag pattern, both global enable values (R2, R3, R4)
    for (int g = 0; g < 2; g++) begin
      for (int e = 0; e < 16; e++) begin
        for (int f = 0; f < 16; f++) begin
          logic pend;
          pend = |(4'(e) & 4'(f));
          intEn = 4'(e); intFlag = 4'(f); globalIntEn = g[0];
          wdtClrCmd = 1;
          step();
          wdtClrCmd = 0;
          chk("R8 clr pulse", wdtClr, 1);
          chk("R8 pd set", powerDownBit, 1);
          chk("R8 to set", timeoutBit, 1);
          step();
          sleepReq = 1;
          step();
          sleepReq = 0;
          if (pend) begin
            chk("R3 nop awake", asleep, 0);
            chk("R3 nop no clr", wdtClr, 0);
            chk("R3 nop pd kept", powerDownBit, 1);
            chk("R3 nop to kept", timeoutBit, 1);
          end else begin
            chk("R4 asleep", asleep, 1);
            chk("R4 clk off", coreClkEn, 0);
            chk("R4 clr pulse", wdtClr, 1);
            chk("R4 pd cleared", powerDownBit, 0);
            chk("R4 to set", timeoutBit, 1);
            step();
            chk("R4 clr pulse ends", wdtClr, 0);
            chk("R5 stays asleep", asleep, 1);
            wakeAndCheck(g[0]);
            chk("R2 wake regardless of gie", asleep, 0);
          end
          intEn = '0; intFlag = '0;
          step();
        end
      end
    end

    // R5: interrupt appears at the same edge as the sleep request
    globalIntEn = 0; intEn = 4'b0001; intFlag = '0;
    step(); step();
    sleepReq = 1; intFlag = 4'b0001;
    step();
    sleepReq = 0;
    chk("R5 coincident gives real sleep", asleep, 1);
    chk("R5 coincident clr pulse", wdtClr, 1);
    step();
    chk("R5 coincident wakes next cycle", asleep, 0);
    chk("R7 coincident resume", resumeInline, 1);
    // R3: pd stays 0 on a no-op after a real sleep
    step();
    sleepReq = 1;
    step();
    sleepReq = 0;
    chk("R3 nop keeps pd low", powerDownBit, 0);
    chk("R3 nop no pulse", wdtClr, 0);
    chk("R3 nop awake", asleep, 0);
    // R8 with a no-op sleep in the same cycle
    sleepReq = 1; wdtClrCmd = 1;
    step();
    sleepReq = 0; wdtClrCmd = 0;
    chk("R8 clr with nop awake", asleep, 0);
    chk("R8 clr with nop pulse", wdtClr, 1);
    chk("R8 clr with nop pd set", powerDownBit, 1);

    // R8 with a real sleep in the same cycle
    intEn = '0; intFlag = '0;
    step(); step();
    sleepReq = 1; wdtClrCmd = 1;
    step();
    sleepReq = 0; wdtClrCmd = 0;
    chk("R8 clr with sleep asleep", asleep, 1);
    chk("R8 clr with sleep pd low", powerDownBit, 0);
    chk("R8 clr with sleep pulse", wdtClr, 1);
    step();
    chk("R8 single pulse", wdtClr, 0);
    // R10: sleep request while asleep
    sleepReq = 1;
    step();
    sleepReq = 0;
    chk("R10 asleep ignore", asleep, 1);
    chk("R10 asleep no pulse", wdtClr, 0);
    // wake with gie, then request during the dummy cycle
    globalIntEn = 1; intEn = '1; intFlag = 4'b1000;
    step(); step();
    chk("R6 dummy awake", asleep, 0);
    chk("R6 dummy no vec", vecLoad, 0);
    sleepReq = 1;
    step();
    sleepReq = 0;
    chk("R10 dummy ignore vec", vecLoad, 1);
    chk("R10 dummy no pulse", wdtClr, 0);
    step();
    chk("R10 dummy stays awake", asleep, 0);
    chk("R10 dummy no late pulse", wdtClr, 0);

    // R9 timeout handling
    intEn = '0; intFlag = '0;
    wdtTimeout = 1;
    step();
    wdtTimeout = 0;
    chk("R9 timeout clears", timeoutBit, 0);
    wdtTimeout = 1; wdtClrCmd = 1;
    step();
    wdtTimeout = 0; wdtClrCmd = 0;
    chk("R9 clr cmd wins", timeoutBit, 1);
    wdtTimeout = 1;
    step();
    chk("R9 timeout clears again", timeoutBit, 0);
    sleepReq = 1;
    step();
    sleepReq = 0; wdtTimeout = 0;
    chk("R9 sleep entry wins", timeoutBit, 1);
    chk("R9 sleep entry asleep", asleep, 1);
    step();
    wakeAndCheck(1'b0);

    done = 1;
    summary();
    $finish;
  end

endmodule